// File: doc/BRIEF.md
# Buffered PWM Compare Register Bank

This block keeps four 12-bit compare points for a PWM timebase: two "set" points (SA, SB) and two "reset" points (RA, RB). A CPU reaches them over an 8-bit register bus. Each 12-bit value is split over two byte addresses, and one shared holding latch pairs the two bytes. The high byte is parked in the latch, and the low-byte write then stores all twelve bits on one edge. A low-byte read does the reverse: it snapshots the upper bits into the latch, so the high-byte read that follows sees a consistent value.

Every register, and one 8-bit output-configuration register, has a staged copy and a live copy. A lock bit in the configuration register decides where writes go. While the lock is clear, a completed write reaches both copies. While it is set, only the staged copy changes and the running PWM cycle keeps the old values. Clearing the lock moves every staged value into its live copy on one edge. Each live compare value is checked against an external counter on every clock. The results are per-register match pulses and sticky flags, and any pending flag raises the interrupt request.

Top module: `pwm_cmp_bank`

## Requirements
- R1: After reset every staged value, live value, latch, flag, configuration bit and the read-data register is 0.
- R2: A write to a compare register's high-byte address (odd address 1, 3, 5 or 7) changes only the holding latch. The staged and live compare values are unchanged.
- R3: A write to a low-byte address (even address 0, 2, 4 or 6 selects SA, RA, SB or RB) stores {latch[3:0], data} into that register's staged copy on the same edge.
- R4: With the lock clear, a low-byte write also updates the live copy on the same edge, so the compare uses the new value from the next clock.
- R5: With the lock set, writes change only staged copies. The live compare values and the live output configuration stay as they were.
- R6: Writing the configuration register (address 8) with bit 5 = 0 while the lock is set copies all four staged compare values and the staged output configuration into their live copies on that one edge.
- R7: Reads return on the clock after the read strobe. A low-byte read returns bits 7:0 of the staged value and loads bits 11:8 into the latch. A high-byte read returns the latch, with bits 7:4 read as 0.
- R8: The configuration register holds the lock at bit 5 and a 3-bit mode field at bits 4:2. Bits 7:6 and 1:0 read as 0.
- R9: match[i] is high for exactly the clocks that follow a clock in which the counter input equalled live value i (bit 0 = SA, 1 = RA, 2 = SB, 3 = RB).
- R10: Flag i (address 9, bit i) is set by a match, stays set, and is cleared only by writing 1 to that bit; irq is high while any flag is set. A match on the same edge wins over a clear.
- R11: The output configuration register (address 10) is staged and live like the compare values. Its live copy drives ocfg, and reads return the staged copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one clock per access |
| bus_re | input | 1 | Read strobe, one clock per access |
| bus_rdata | output | 8 | Read data, valid the clock after bus_re |
| cnt_val | input | 12 | PWM counter value to compare against |
| match | output | 4 | Per-register match pulses |
| irq | output | 1 | Compare interrupt request |
| ocfg | output | 8 | Live output configuration |

## Verification
Compare values are written in both lock states. The unlocked writes show that a change takes effect on the next clock. The locked writes show that the live values stay frozen until the single release edge. A lone high-byte write separates latch-only behaviour from a real register update, and read-back pairs show whether the latch snapshot keeps the two halves of a value together. A full counter sweep from 0 to 4095 tests every comparator against four different live values at once. Flag clears, issued with and without a coincident match, show whether flags are sticky and whether a set wins over a clear.

// File: rtl/pwm_cmp_pkg.sv
// Shared constants and types for the buffered PWM compare register bank.
// Assumes a 4-bit register address space with the map fixed below.
package pwm_cmp_pkg;

    localparam int ADDR_W = 4;

    // Compare register index order; match/flag bit i follows this order.
    typedef enum logic [1:0] {
        CMP_SA = 2'd0,
        CMP_RA = 2'd1,
        CMP_SB = 2'd2,
        CMP_RB = 2'd3
    } cmp_idx_e;

    // Register map beyond the compare byte pairs at addresses 0..7.
    localparam logic [ADDR_W-1:0] ADR_CFG  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_OCFG = 4'd10;

    // Configuration register field positions.
    localparam int CFG_LOCK_BIT = 5;
    localparam int CFG_MODE_LSB = 2;
    localparam int CFG_MODE_W   = 3;

endpackage

// File: rtl/cmp_reg_slot.sv
// One staged/live register pair.
// Staged copy takes every write. Live copy takes the write only when unlocked,
// and takes the whole staged value on a commit pulse.
// Assumes commit and wr_en never coincide (one bus access per clock).
module cmp_reg_slot #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         locked,
    input  logic         commit,
    output logic [W-1:0] shd,
    output logic [W-1:0] act
);

    // Staged copy: follows every completed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shd <= '0;
        else if (wr_en)
            shd <= wr_data;
    end

    // Live copy: bulk commit, or write-through when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else if (commit)
            act <= shd;
        else if (wr_en && !locked)
            act <= wr_data;
    end

endmodule

// File: rtl/cmp_byte_if.sv
// Byte-wide register interface: address decode, shared high-byte latch,
// configuration register (lock + mode), flag-clear strobes and read mux.
// Assumes bus_we and bus_re are never high together and that compare
// registers occupy byte pairs at addresses 0 .. 2*N_CMP-1 (even = low byte).
module cmp_byte_if
    import pwm_cmp_pkg::*;
#(
    parameter int N_CMP = 4,
    parameter int VAL_W = 12,
    parameter int BUS_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BUS_W-1:0]            bus_wdata,
    input  logic                        bus_we,
    input  logic                        bus_re,
    output logic [BUS_W-1:0]            bus_rdata,
    input  logic [N_CMP-1:0][VAL_W-1:0] shd_val,
    input  logic [BUS_W-1:0]            ocfg_shd,
    input  logic [N_CMP-1:0]            flags,
    output logic [N_CMP-1:0]            slot_we,
    output logic [VAL_W-1:0]            slot_wdata,
    output logic                        ocfg_we,
    output logic                        lock,
    output logic                        commit,
    output logic [N_CMP-1:0]            flag_clr,
    output logic [BUS_W-1:0]            hold_latch
);

    localparam int HI_W  = VAL_W - BUS_W;
    localparam int IDX_W = $clog2(N_CMP);
    localparam logic [ADDR_W-1:0] CMP_END = ADDR_W'(2 * N_CMP);

    logic                  is_cmp;
    logic                  is_hi;
    logic [IDX_W-1:0]      idx;
    logic [CFG_MODE_W-1:0] mode_q;
    logic                  lock_q;
    logic [BUS_W-1:0]      cfg_rd;

    // Decode the compare byte-pair address fields.
    always_comb begin
        is_cmp = (bus_addr < CMP_END);
        is_hi  = bus_addr[0];
        idx    = bus_addr[IDX_W:1];
    end

    // Shared latch: loaded by high-byte writes and by low-byte read snapshots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_latch <= '0;
        else if (bus_we && is_cmp && is_hi)
            hold_latch <= bus_wdata;
        else if (bus_re && is_cmp && !is_hi)
            hold_latch <= {{(BUS_W-HI_W){1'b0}}, shd_val[idx][VAL_W-1:BUS_W]};
    end

    // Per-slot write strobes for completed (low-byte) writes.
    always_comb begin
        slot_we = '0;
        if (bus_we && is_cmp && !is_hi)
            slot_we[idx] = 1'b1;
        slot_wdata = {hold_latch[HI_W-1:0], bus_wdata};
    end

    // Configuration register: lock bit and mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            mode_q <= '0;
        end else if (bus_we && bus_addr == ADR_CFG) begin
            lock_q <= bus_wdata[CFG_LOCK_BIT];
            mode_q <= bus_wdata[CFG_MODE_LSB +: CFG_MODE_W];
        end
    end

    // Commit pulse, output-config strobe and write-one-to-clear flag strobes.
    always_comb begin
        lock     = lock_q;
        commit   = bus_we && (bus_addr == ADR_CFG) && lock_q && !bus_wdata[CFG_LOCK_BIT];
        ocfg_we  = bus_we && (bus_addr == ADR_OCFG);
        flag_clr = (bus_we && bus_addr == ADR_FLAG) ? bus_wdata[N_CMP-1:0] : '0;
        cfg_rd   = '0;
        cfg_rd[CFG_LOCK_BIT] = lock_q;
        cfg_rd[CFG_MODE_LSB +: CFG_MODE_W] = mode_q;
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re) begin
            if (is_cmp && is_hi)
                bus_rdata <= {{(BUS_W-HI_W){1'b0}}, hold_latch[HI_W-1:0]};
            else if (is_cmp)
                bus_rdata <= shd_val[idx][BUS_W-1:0];
            else if (bus_addr == ADR_CFG)
                bus_rdata <= cfg_rd;
            else if (bus_addr == ADR_FLAG)
                bus_rdata <= {{(BUS_W-N_CMP){1'b0}}, flags};
            else if (bus_addr == ADR_OCFG)
                bus_rdata <= ocfg_shd;
            else
                bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/cmp_match_unit.sv
// Comparators and sticky interrupt flags.
// Compares every live value with the counter each clock, registers the
// result as match pulses, and keeps sticky flags (set wins over clear).
module cmp_match_unit #(
    parameter int N_CMP = 4,
    parameter int VAL_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [VAL_W-1:0]            cnt_val,
    input  logic [N_CMP-1:0][VAL_W-1:0] act_val,
    input  logic [N_CMP-1:0]            flag_clr,
    output logic [N_CMP-1:0]            match,
    output logic [N_CMP-1:0]            flags,
    output logic                        irq
);

    logic [N_CMP-1:0] eq;

    // One equality comparator per live value.
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        assign eq[i] = (cnt_val == act_val[i]);
    end

    // Registered match pulses and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match <= '0;
            flags <= '0;
        end else begin
            match <= eq;
            flags <= (flags & ~flag_clr) | eq;
        end
    end

    // Interrupt request while any flag is pending.
    assign irq = |flags;

endmodule

// File: rtl/pwm_cmp_bank.sv
// Top: four staged/live 12-bit compare registers plus a staged/live output
// configuration byte, reached through a byte bus with a shared high-byte
// latch, and compared every clock against an external counter.
// Assumes one bus access per clock and a synchronous active-low reset.
module pwm_cmp_bank
    import pwm_cmp_pkg::*;
#(
    parameter int N_CMP = 4,
    parameter int VAL_W = 12,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [VAL_W-1:0]  cnt_val,
    output logic [N_CMP-1:0]  match,
    output logic              irq,
    output logic [BUS_W-1:0]  ocfg
);

    logic [N_CMP-1:0][VAL_W-1:0] shd_val;
    logic [N_CMP-1:0][VAL_W-1:0] act_val;
    logic [N_CMP-1:0]            slot_we;
    logic [VAL_W-1:0]            slot_wdata;
    logic                        ocfg_we;
    logic [BUS_W-1:0]            ocfg_shd;
    logic                        lock_q;
    logic                        commit;
    logic [N_CMP-1:0]            flag_clr;
    logic [N_CMP-1:0]            flag_q;
    logic [BUS_W-1:0]            hold_latch;

    cmp_byte_if #(.N_CMP(N_CMP), .VAL_W(VAL_W), .BUS_W(BUS_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .shd_val    (shd_val),
        .ocfg_shd   (ocfg_shd),
        .flags      (flag_q),
        .slot_we    (slot_we),
        .slot_wdata (slot_wdata),
        .ocfg_we    (ocfg_we),
        .lock       (lock_q),
        .commit     (commit),
        .flag_clr   (flag_clr),
        .hold_latch (hold_latch)
    );

    // One staged/live pair per compare register.
    for (genvar i = 0; i < N_CMP; i++) begin : g_slot
        cmp_reg_slot #(.W(VAL_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_we[i]),
            .wr_data (slot_wdata),
            .locked  (lock_q),
            .commit  (commit),
            .shd     (shd_val[i]),
            .act     (act_val[i])
        );
    end

    // Staged/live pair for the output configuration byte.
    cmp_reg_slot #(.W(BUS_W)) u_ocfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ocfg_we),
        .wr_data (bus_wdata),
        .locked  (lock_q),
        .commit  (commit),
        .shd     (ocfg_shd),
        .act     (ocfg)
    );

    cmp_match_unit #(.N_CMP(N_CMP), .VAL_W(VAL_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .act_val  (act_val),
        .flag_clr (flag_clr),
        .match    (match),
        .flags    (flag_q),
        .irq      (irq)
    );

endmodule

// File: rtl/pwm_cmp_bank_chk.sv
// Assertion checker for pwm_cmp_bank, attached by bind below.
// Observes bus ports plus staged/live state, latch, lock and flags.
module pwm_cmp_bank_chk
    import pwm_cmp_pkg::*;
#(
    parameter int N_CMP = 4,
    parameter int VAL_W = 12,
    parameter int BUS_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [3:0]                  bus_addr,
    input logic [BUS_W-1:0]            bus_wdata,
    input logic                        bus_we,
    input logic                        bus_re,
    input logic [BUS_W-1:0]            bus_rdata,
    input logic [VAL_W-1:0]            cnt_val,
    input logic [N_CMP-1:0]            match,
    input logic                        irq,
    input logic [N_CMP-1:0][VAL_W-1:0] shd_val,
    input logic [N_CMP-1:0][VAL_W-1:0] act_val,
    input logic                        lock_q,
    input logic [BUS_W-1:0]            hold_latch,
    input logic [N_CMP-1:0]            flag_q
);

    localparam int HI_W = VAL_W - BUS_W;
    localparam logic [3:0] CMP_END = 4'(2 * N_CMP);

    p_hi_write_latch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr < CMP_END && bus_addr[0]) |=> ($stable(shd_val) && $stable(act_val)));

    p_locked_live_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !(bus_we && bus_addr == ADR_CFG)) |=> $stable(act_val));

    p_release_commits_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> (act_val == $past(shd_val)));

    p_hi_read_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr < CMP_END && bus_addr[0]) |=> (bus_rdata[BUS_W-1:HI_W] == '0));

    p_cfg_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADR_CFG) |=> (bus_rdata[7:6] == 2'b00 && bus_rdata[1:0] == 2'b00));

    p_irq_rise_from_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (match != '0));

    for (genvar i = 0; i < N_CMP; i++) begin : g_slot_chk
        p_lo_write_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == 4'(2 * i))
            |=> (shd_val[i] == {$past(hold_latch[HI_W-1:0]), $past(bus_wdata)}));

        p_unlocked_write_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && !lock_q && bus_addr == 4'(2 * i)) |=> (act_val[i] == shd_val[i]));

        p_match_on_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_val == act_val[i]) |=> match[i]);

        p_no_match_unequal_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_val != act_val[i]) |=> !match[i]);

        p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(bus_we && bus_addr == ADR_FLAG && bus_wdata[i])) |=> flag_q[i]);
    end

endmodule

bind pwm_cmp_bank pwm_cmp_bank_chk #(.N_CMP(N_CMP), .VAL_W(VAL_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .cnt_val    (cnt_val),
    .match      (match),
    .irq        (irq),
    .shd_val    (shd_val),
    .act_val    (act_val),
    .lock_q     (lock_q),
    .hold_latch (hold_latch),
    .flag_q     (flag_q)
);

// File: tb/sim_pwm_cmp_bank.sv
`timescale 1ns/100ps
// Bench: behavioural reference model updated on each rising edge and
// compared with the outputs on every falling edge, plus directed checks.
module sim_pwm_cmp_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [11:0] cnt_val = '0;
    logic [3:0]  match;
    logic        irq;
    logic [7:0]  ocfg;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_cmp_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .match(match), .irq(irq), .ocfg(ocfg)
    );

    // Reference model state.
    int m_shd[4];
    int m_act[4];
    int m_latch, m_lock, m_mode, m_ocfg_s, m_ocfg_a, m_flag, m_match, m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_shd[k]) begin m_shd[k] = 0; m_act[k] = 0; end
            m_latch = 0; m_lock = 0; m_mode = 0; m_ocfg_s = 0; m_ocfg_a = 0;
            m_flag = 0; m_match = 0; m_rdata = 0;
        end else begin
            int a, w, eqv, clr, r;
            a = bus_addr; w = bus_wdata; eqv = 0; clr = 0;
            for (int k = 0; k < 4; k++)
                if (cnt_val == m_act[k]) eqv |= (1 << k);
            if (bus_we && a == 9) clr = w & 15;
            if (bus_re) begin
                if (a < 8 && a % 2 == 1) r = m_latch & 15;
                else if (a < 8) begin r = m_shd[a/2] & 255; end
                else if (a == 8) r = (m_lock << 5) | (m_mode << 2);
                else if (a == 9) r = m_flag;
                else if (a == 10) r = m_ocfg_s;
                else r = 0;
                m_rdata = r;
                if (a < 8 && a % 2 == 0) m_latch = m_shd[a/2] >> 8;
            end
            if (bus_we) begin
                if (a < 8 && a % 2 == 1) m_latch = w;
                else if (a < 8) begin
                    m_shd[a/2] = ((m_latch & 15) << 8) | w;
                    if (!m_lock) m_act[a/2] = m_shd[a/2];
                end else if (a == 8) begin
                    if (m_lock && !((w >> 5) & 1)) begin
                        for (int k = 0; k < 4; k++) m_act[k] = m_shd[k];
                        m_ocfg_a = m_ocfg_s;
                    end
                    m_lock = (w >> 5) & 1;
                    m_mode = (w >> 2) & 7;
                end else if (a == 10) begin
                    m_ocfg_s = w;
                    if (!m_lock) m_ocfg_a = w;
                end
            end
            m_match = eqv;
            m_flag = (m_flag & ~clr) | eqv;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Per-clock comparison with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(match), m_match, "R9 match vs model");
            chk(int'(irq), int'(m_flag != 0), "R10 irq vs model");
            chk(int'(bus_rdata), m_rdata, "R7 rdata vs model");
            chk(int'(ocfg), m_ocfg_a, "R11 ocfg vs model");
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 4'(a); bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic wr12(input int idx, input int v);
        wr(2*idx + 1, v >> 8);
        wr(2*idx, v & 255);
    endtask

    task automatic rd12(input int idx, output int v);
        int lo, hi;
        rd(2*idx, lo);
        rd(2*idx + 1, hi);
        v = (hi << 8) | lo;
    endtask

    // Set the counter, wait for the registered match, return match bits.
    task automatic probe(input int c, output int m);
        @(negedge clk);
        cnt_val = 12'(c);
        @(negedge clk);
        m = int'(match);
        @(negedge clk);
        cnt_val = 12'hF00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cnt_val = 12'hF00;
        // R1: reset state
        chk(int'(bus_rdata), 0, "R1 rdata after reset");
        chk(int'(ocfg), 0, "R1 ocfg after reset");
        for (int k = 0; k < 4; k++) begin
            rd12(k, v); chk(v, 0, "R1 compare value after reset");
        end
        rd(8, v); chk(v, 0, "R1 config after reset");
        wr(9, 15);
        rd(9, v); chk(v, 0, "R10 flags cleared by write-one");
        // R4: unlocked write goes live
        wr12(0, 12'h5A3);
        rd12(0, v); chk(v, 12'h5A3, "R3 SA read back");
        probe(12'h5A3, m); chk(m & 1, 1, "R4 SA live after unlocked write");
        // R2: high-byte write alone leaves register unchanged
        wr(3, 8'h07);
        rd(2, v); chk(v, 0, "R2 RA low after lone high write");
        rd(3, v); chk(v, 0, "R2 RA high after lone high write");
        // R8: config layout, unused bits read 0
        wr(8, 8'hFF);
        rd(8, v); chk(v, 8'h3C, "R8 config read with unused bits zero");
        // R5: locked writes are staged only
        wr12(1, 12'h123); wr12(2, 12'hABC); wr12(3, 12'hFFF); wr12(0, 12'h001);
        wr(10, 8'h55);
        chk(int'(ocfg), 0, "R11 ocfg held while locked");
        probe(12'h123, m); chk(m & 2, 0, "R5 RA not live while locked");
        probe(12'h5A3, m); chk(m & 1, 1, "R5 SA keeps old live value");
        rd12(2, v); chk(v, 12'hABC, "R3 SB staged value");
        rd(10, v); chk(v, 8'h55, "R11 ocfg read returns staged");
        // R6: release commits everything at once
        wr(8, 8'h00);
        chk(int'(ocfg), 8'h55, "R6 ocfg committed on release");
        probe(12'h123, m); chk(m, 2, "R6 RA committed");
        probe(12'hABC, m); chk(m, 4, "R6 SB committed");
        probe(12'hFFF, m); chk(m, 8, "R6 RB committed");
        probe(12'h001, m); chk(m, 1, "R6 SA committed");
        // R7: high read of RB upper nibble zero
        rd(6, v); chk(v, 8'hFF, "R7 RB low byte");
        rd(7, v); chk(v, 8'h0F, "R7 RB high byte upper bits zero");
        // R10: sticky flags, write-one clear, set wins
        rd(9, v); chk(v, 15, "R10 flags sticky after matches");
        wr(9, 8'h02);
        rd(9, v); chk(v, 13, "R10 single flag cleared");
        @(negedge clk); cnt_val = 12'h001;
        bus_addr = 4'd9; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0; cnt_val = 12'hF00;
        rd(9, v); chk(v & 1, 1, "R10 set wins over clear");
        wr(9, 15);
        chk(int'(irq), 0, "R10 irq low after all cleared");
        // R9: full counter sweep, model compared every clock
        for (int c = 0; c < 4096; c++) begin
            @(negedge clk); cnt_val = 12'(c);
        end
        @(negedge clk);
        cnt_val = 12'hF00;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule